// File: doc/BRIEF.md
# Sequential-Access Packet Buffer Port

This block is the host's window into a 2048-byte on-chip packet buffer. The buffer is split into eight 256-byte pages. The host does not address the buffer directly. It loads an 11-bit pointer through two byte registers, one for the high part and one for the low part, and then moves bytes through a single data register. The pointer advances by one after every transfer, so a whole packet can be written or read as a stream of accesses to one register offset.

A direction bit in the high pointer register selects read or write streaming. In read mode the block fetches the addressed byte ahead of time, so the data register already holds it when the host reads. Each read then fetches the next byte.

The block also holds the node identifier. Writing a nonzero identifier starts a short self-initialization that places a fixed marker byte and the identifier at the bottom of the buffer. The host can later read these back as a sanity check. While the identifier is zero the node stays dormant.

Top module: `pkt_buf_port`

## Requirements
- R1: After reset the pointer is 000h and in write direction, the node identifier is 00h, `busy` and `core_active` are low, and the data register (offset 4) reads 00h.
- R2: A write to offset 2 loads pointer bits [10:8] from data bits [2:0] and the direction from bit 7 (1 = read). A write to offset 3 loads pointer bits [7:0]. Reading offset 2 returns {direction, 0000b, pointer[10:8]} and reading offset 3 returns pointer[7:0].
- R3: In write direction, a write to offset 4 stores the byte at the pointer address and advances the pointer by one.
- R4: The pointer advances from 7FFh to 000h.
- R5: In read direction, no later than two cycles after a pointer load or a data read, offset 4 shows the byte at the next unread address, and the pointer then reads back as that address plus one.
- R6: Streaming in either direction crosses a 256-byte page boundary with no break in the byte sequence.
- R7: A write of a nonzero value to offset 1 stores it as the node identifier. The block then raises `busy` for exactly two cycles, starting on the next clock edge, and during them writes D1h to address 000h and then the identifier to address 001h.
- R8: `busy` never stays high for `INIT_LIMIT` consecutive cycles.
- R9: While the node identifier is 00h, `busy` and `core_active` stay low and the buffer is left untouched. A write of 00h to offset 1 starts no initialization.
- R10: While `busy` is high, data-register transfers are ignored: no buffer byte changes and the pointer does not move.
- R11: `core_active` is high exactly when the node identifier is nonzero and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register offset: 1 node identifier, 2 pointer high, 3 pointer low, 4 data |
| wr_en | input | 1 | Register write strobe, one cycle per access |
| rd_en | input | 1 | Register read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected offset (combinational) |
| busy | output | 1 | Self-initialization writes in progress |
| core_active | output | 1 | Node awake: identifier nonzero and initialization done |

## Verification
Register readback is combinational, so the bench samples `rdata` in the same cycle as the read strobe. The one exception is a read-direction prefetch: it issues its buffer read on the edge after the triggering access and captures the byte on the edge after that. For this reason the bench always lets three cycles pass after a pointer load or a data read before the next read of offset 4. `busy` is sampled at the falling edge after each of the three edges that follow a node identifier write, so the bench sees the high, high, low pattern. A data write placed on the middle edge shows that transfers are dropped while `busy` is high. The pointer written with random starts and lengths is checked against a bench successor function that restates the wrap as a compare.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
  localparam logic [2:0] OFS_NODE = 3'd1;
  localparam logic [2:0] OFS_PHI  = 3'd2;
  localparam logic [2:0] OFS_PLO  = 3'd3;
  localparam logic [2:0] OFS_DATA = 3'd4;
  localparam int         DIR_BIT  = 7;
  localparam logic [7:0] MARK_BYTE = 8'hD1;

  typedef enum logic [1:0] {INIT_IDLE, INIT_MARK, INIT_ID} init_st_e;

  // successor of a pointer, masked to the buffer size
  function automatic logic [15:0] ptr_next(input logic [15:0] p, input logic [15:0] mask);
    return (p + 16'd1) & mask;
  endfunction
endpackage

// File: rtl/pbp_ptr.sv
module pbp_ptr
  import pbp_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic              step,
  input  logic [7:0]        wdata,
  output logic [ADDR_W-1:0] ptr,
  output logic              rd_mode
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [15:0] MASK = 16'((1 << ADDR_W) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      rd_mode <= 1'b0;
    end else if (ld_hi) begin
      ptr[ADDR_W-1:8] <= wdata[HI_W-1:0];
      rd_mode         <= wdata[DIR_BIT];
    end else if (ld_lo) begin
      ptr[7:0] <= wdata;
    end else if (step) begin
      ptr <= ADDR_W'(ptr_next(16'(ptr), MASK));
    end
  end

  // R4: a step moves the pointer to its successor, wrapping at the top
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_hi && !ld_lo) |=> ptr == ADDR_W'($past(ptr) + 1'b1));
endmodule

// File: rtl/pbp_init.sv
module pbp_init
  import pbp_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int INIT_LIMIT = 4800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nid_wr,
  input  logic              nid_nonzero,
  input  logic [7:0]        node_id,
  output logic              busy,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [7:0]        wbyte
);
  localparam int CNT_W = $clog2(INIT_LIMIT + 1) + 1;

  init_st_e          state;
  logic [CNT_W-1:0]  busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= INIT_IDLE;
    end else if (nid_wr) begin
      state <= nid_nonzero ? INIT_MARK : INIT_IDLE;
    end else begin
      case (state)
        INIT_MARK: state <= INIT_ID;
        INIT_ID:   state <= INIT_IDLE;
        default:   state <= INIT_IDLE;
      endcase
    end
  end

  assign busy  = (state != INIT_IDLE);
  assign we    = busy;
  assign waddr = (state == INIT_ID) ? ADDR_W'(1) : '0;
  assign wbyte = (state == INIT_ID) ? node_id : MARK_BYTE;

  // consecutive busy cycles, for the bound check only
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_cnt <= '0;
    else if (busy_cnt != '1) busy_cnt <= busy_cnt + 1'b1;
  end

  a_r8_init_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_cnt < CNT_W'(INIT_LIMIT));

  a_r7_mark_then_id: assert property (@(posedge clk) disable iff (!rst_n)
    (state == INIT_MARK && !nid_wr) |=> state == INIT_ID);
endmodule

// File: rtl/pbp_ram.sv
module pbp_ram #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= din;
    q <= mem[addr];
  end
endmodule

// File: rtl/pkt_buf_port.sv
module pkt_buf_port
  import pbp_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int INIT_LIMIT = 4800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       busy,
  output logic       core_active
);
  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] ptr;
  logic              rd_mode;
  logic [7:0]        node_id;
  logic [7:0]        dreg;
  logic              pf_pend, fetch_q;
  logic              init_we;
  logic [ADDR_W-1:0] init_addr;
  logic [7:0]        init_byte;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [7:0]        ram_din, ram_q;

  // named access events
  wire nid_wr       = wr_en && (reg_sel == OFS_NODE);
  wire ld_hi        = wr_en && (reg_sel == OFS_PHI);
  wire ld_lo        = wr_en && (reg_sel == OFS_PLO);
  wire host_wr_data = wr_en && (reg_sel == OFS_DATA) && !rd_mode && !busy;
  wire host_rd_data = rd_en && (reg_sel == OFS_DATA) && rd_mode && !busy;
  wire fetch        = pf_pend && rd_mode && !busy;
  wire step         = host_wr_data || fetch;
  wire pf_set       = (ld_hi && wdata[DIR_BIT]) || (ld_lo && rd_mode) || host_rd_data;

  pbp_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ld_hi(ld_hi), .ld_lo(ld_lo), .step(step),
    .wdata(wdata), .ptr(ptr), .rd_mode(rd_mode)
  );

  pbp_init #(.ADDR_W(ADDR_W), .INIT_LIMIT(INIT_LIMIT)) u_init (
    .clk(clk), .rst_n(rst_n), .nid_wr(nid_wr), .nid_nonzero(wdata != 8'h00),
    .node_id(node_id), .busy(busy), .we(init_we), .waddr(init_addr), .wbyte(init_byte)
  );

  // initialization owns the buffer port while it runs
  always_comb begin
    if (init_we) begin
      ram_we = 1'b1; ram_addr = init_addr; ram_din = init_byte;
    end else begin
      ram_we = host_wr_data; ram_addr = ptr; ram_din = wdata;
    end
  end

  pbp_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .din(ram_din), .q(ram_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      node_id <= 8'h00;
      pf_pend <= 1'b0;
      fetch_q <= 1'b0;
      dreg    <= 8'h00;
    end else begin
      if (nid_wr) node_id <= wdata;
      if (pf_set) pf_pend <= 1'b1;
      else if (fetch || !rd_mode) pf_pend <= 1'b0;
      fetch_q <= fetch;
      if (fetch_q) dreg <= ram_q;
    end
  end

  assign core_active = (node_id != 8'h00) && !busy;

  always_comb begin
    case (reg_sel)
      OFS_NODE: rdata = node_id;
      OFS_PHI:  rdata = {rd_mode, {(7-HI_W){1'b0}}, ptr[ADDR_W-1:8]};
      OFS_PLO:  rdata = ptr[7:0];
      OFS_DATA: rdata = dreg;
      default:  rdata = 8'h00;
    endcase
  end

  a_r9_dormant: assert property (@(posedge clk) disable iff (!rst_n)
    (node_id == 8'h00) |-> !busy && !core_active);

  a_r10_busy_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ld_hi && !ld_lo) |=> $stable(ptr));

  a_r7_init_owns_port: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ram_we && (ram_addr <= ADDR_W'(1)));
endmodule

// File: tb/test_pkt_buf_port.sv
module test_pkt_buf_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] sel;
  logic       wr_en, rd_en;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       busy, core_active;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mdl [0:2047];

  localparam logic [2:0] S_NODE = 3'd1, S_PHI = 3'd2, S_PLO = 3'd3, S_DATA = 3'd4;

  pkt_buf_port i_pkt_buf_port (
    .clk(clk), .rst_n(rst_n), .reg_sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .busy(busy), .core_active(core_active)
  );

  always #10 clk = ~clk;

  function automatic int nxt(input int p);
    return (p == 2047) ? 0 : p + 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk); sel = s; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_ptr(input int a, input logic rdir);
    wr(S_PHI, {rdir, 4'b0000, 3'(a >> 8)});
    wr(S_PLO, 8'(a));
    repeat (3) @(negedge clk);
  endtask

  task automatic get_ptr(output int a);
    logic [7:0] h, l;
    rd(S_PHI, h);
    rd(S_PLO, l);
    a = {h[2:0], l};
  endtask

  task automatic stream_write(input int a, input int n);
    set_ptr(a, 1'b0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      wr(S_DATA, b);
      mdl[a] = b;
      a = nxt(a);
    end
  endtask

  task automatic stream_read(input string tag, input int a, input int n);
    set_ptr(a, 1'b1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      rd(S_DATA, b);
      chk(tag, b, mdl[a]);
      a = nxt(a);
    end
  endtask

  initial begin
    logic [7:0] v;
    int p, e;
    void'($urandom(32'd4711));
    rst_n = 1'b0; sel = 3'd0; wr_en = 1'b0; rd_en = 1'b0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 core_active", core_active, 0);
    rd(S_PHI, v);  chk("R1 ptr hi", v, 8'h00);
    rd(S_PLO, v);  chk("R1 ptr lo", v, 8'h00);
    rd(S_NODE, v); chk("R1 node id", v, 8'h00);
    rd(S_DATA, v); chk("R1 data reg", v, 8'h00);

    // R9 dormant: zero node id starts nothing and leaves bytes 0 and 1 alone
    wr(S_DATA, 8'h55); mdl[0] = 8'h55;
    wr(S_DATA, 8'h66); mdl[1] = 8'h66;
    wr(S_NODE, 8'h00);
    chk("R9 busy after zero id", busy, 0);
    chk("R9 core_active with zero id", core_active, 0);
    stream_read("R9 buffer untouched", 0, 2);

    // R2 pointer registers and readback, R5 prefetch pointer
    set_ptr(11'h5A3, 1'b1);
    rd(S_PHI, v); chk("R2 ptr hi readback", v, 8'h85);
    rd(S_PLO, v); chk("R5 ptr after prefetch", v, 8'hA4);

    // R7 / R10 / R11 initialization, with a data write dropped while busy
    set_ptr(100, 1'b0);
    wr(S_DATA, 8'h77); mdl[100] = 8'h77;
    set_ptr(100, 1'b0);
    @(negedge clk); sel = S_NODE; wdata = 8'h3C; wr_en = 1'b1;
    @(negedge clk); sel = S_DATA; wdata = 8'hAA;
    chk("R7 busy cycle 1", busy, 1);
    chk("R11 core_active low while busy", core_active, 0);
    @(negedge clk); wr_en = 1'b0;
    chk("R7 busy cycle 2", busy, 1);
    @(negedge clk);
    chk("R7 busy ends after two cycles", busy, 0);
    chk("R11 core_active after init", core_active, 1);
    get_ptr(p); chk("R10 ptr frozen while busy", p, 100);
    mdl[0] = 8'hD1; mdl[1] = 8'h3C;
    stream_read("R7 init pattern", 0, 2);
    stream_read("R10 byte not written while busy", 100, 1);
    rd(S_NODE, v); chk("R7 node id stored", v, 8'h3C);

    // R4 wrap at the top of the buffer
    stream_write(11'h7FE, 4);
    get_ptr(p); chk("R4 ptr wrapped", p, 2);
    stream_read("R4 read across wrap", 11'h7FE, 4);

    // R6 page boundary in both directions
    stream_write(11'h0FC, 8);
    stream_read("R6 read across page", 11'h0FC, 8);
    get_ptr(p); chk("R5 ptr after read stream", p, 11'h105);

    // R3 / R5 random streams
    for (int it = 0; it < 20; it++) begin
      int a, n;
      a = int'($urandom % 2048);
      n = 1 + int'($urandom % 24);
      stream_write(a, n);
      e = a;
      for (int k = 0; k < n; k++) e = nxt(e);
      get_ptr(p); chk("R3 ptr after write stream", p, e);
      stream_read("R5 random readback", a, n);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule